// File: doc/BRIEF.md
# Instruction-Fetch Address Break Controller

This block sits beside a CPU's instruction-fetch path. It compares every fetch address against a programmable break address. When a fetch hits that address while the break is enabled, the block raises a one-cycle break request. It does not stop the processor at once. It waits until the instruction at the break address has executed. If that instruction was a short one, the block also lets the already-prefetched instruction after it complete. Only then does it take over the bus for a fixed exception sequence.

The sequence is a run of internal cycles, one vector read and two stack writes below the stack pointer. After that, fetching resumes at the return address. The return address is the fetch address of the first instruction that was fetched but did not execute. It is driven on its own output so that stack-save logic can store it.

The block emits one bus-cycle record on every clock: a cycle-type code and an address. The records form a plain, unconditional stream. It has no valid/ready handshake and applies no back-pressure, because each record describes a bus cycle that has already been committed. A consumer must take every record in the cycle it appears. The configuration write port and the execute-side strobes are plain single-cycle pulses.

Top module: `fetch_break_unit`

## Requirements
- R1: After reset, the record type is IDLE (code 0), `brk_req` is low, `ret_addr` is 0, the break address is 0 and the break is disabled.
- R2: In normal running, a clock with `fetch_vld` high produces, one clock later, a FETCH record (code 1) carrying `fetch_addr`. A clock without it produces an IDLE record.
- R3: A configuration write with `cfg_sel`=0 loads `cfg_wdata` as the break address. A write with `cfg_sel`=1 loads `cfg_wdata[0]` as the enable. While enabled and in normal running, a fetch whose address equals the break address raises `brk_req` for exactly the following clock.
- R4: While the enable is 0, a fetch at the break address raises no request and starts no exception sequence.
- R5: The first `insn_done` pulse in a clock after the hitting fetch belongs to the break instruction. If `insn_long`=0 (2-byte, one state), the next `insn_done` pulse also executes. The exception starts with that pulse, and the return address is the break address plus the lengths of both instructions (2 or 4 bytes each).
- R6: If the break instruction completes with `insn_long`=1 (4 bytes, two states), the exception starts with that pulse, and the return address is the break address plus 4.
- R7: From the completion that starts it, the exception produces these records in order: INTERNAL (code 2) twice, VECTOR (code 3) at 0x0036, then STACK (code 4) at SP-2 and at SP-4. SP is `sp_in` sampled on the starting clock.
- R8: A matching fetch while a break is pending or an exception is running raises no request. Fetch strobes during the exception cycles produce no records, including a strobe in the clock that starts the exception.
- R9: After the second stack write, the next record is a FETCH at the return address, and normal running resumes. `ret_addr` shows the return address from the starting clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects break address, 1 selects enable |
| cfg_wdata | input | 16 | Configuration write data |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| insn_done | input | 1 | An instruction finished executing this clock |
| insn_long | input | 1 | Finished instruction was 4 bytes (1) or 2 bytes (0) |
| sp_in | input | 16 | Current stack pointer |
| brk_req | output | 1 | One-clock break request |
| cyc_type | output | 3 | Bus-cycle type code of the current record |
| cyc_addr | output | 16 | Bus-cycle address of the current record |
| ret_addr | output | 16 | Return address for the stack-save logic |

## Verification
The break path is tried with three completion patterns: a short break instruction followed by a short neighbour, a long break instruction, and a short break instruction followed by a long neighbour. These patterns separate the one-trailing-instruction rule from the stop-now rule and show whether the return address sums both lengths. Matching fetches are also sent while the break is disabled, while a break is pending and during the exception. These show that the request is gated by the enable bit and by the running state, and that the exception cycles cannot be disturbed. Non-matching fetches with gaps, a second break address and a changed stack pointer separate plain pass-through from the compare, and show whether the stack addresses follow `sp_in`.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_FETCH    = 3'd1,
    CYC_INTERNAL = 3'd2,
    CYC_VECTOR   = 3'd3,
    CYC_STACK    = 3'd4
  } cyc_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ARMED,
    ST_TRAIL,
    ST_INT,
    ST_VEC,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_RESUME
  } seq_st_e;

endpackage

// File: rtl/fbu_cfg.sv
module fbu_cfg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] brk_addr,
  output logic          brk_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr <= '0;
      brk_en   <= 1'b0;
    end else if (we) begin
      if (sel) brk_en   <= wdata[0];
      else     brk_addr <= wdata;
    end
  end

endmodule

// File: rtl/fbu_match.sv
module fbu_match #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] brk_addr,
  input  logic          brk_en,
  input  logic          run,
  output logic          hit,
  output logic          brk_req
);

  // a hit only counts while no break is pending or being serviced
  assign hit = run && brk_en && fetch_vld && (fetch_addr == brk_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= hit;
  end

endmodule

// File: rtl/fbu_seq.sv
module fbu_seq
  import fbu_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          INT_CYCLES = 2,
  parameter logic [15:0] VEC_ADDR   = 16'h0036
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          insn_done,
  input  logic          insn_long,
  input  logic [AW-1:0] sp_in,
  output logic          run,
  output logic [2:0]    nxt_type,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] ret_addr
);

  localparam int          CW      = $clog2(INT_CYCLES > 1 ? INT_CYCLES : 2);
  localparam logic [AW-1:0] SHORT_B = AW'(2);
  localparam logic [AW-1:0] LONG_B  = AW'(4);
  localparam logic [AW-1:0] VEC_A   = AW'(VEC_ADDR);

  seq_st_e       st_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] ret_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] ilen;
  logic          go;

  assign run  = (st_q == ST_RUN);
  assign ilen = insn_long ? LONG_B : SHORT_B;
  assign go   = insn_done && ((st_q == ST_TRAIL) || (st_q == ST_ARMED && insn_long));

  always_comb begin
    nxt_type = 3'(CYC_IDLE);
    nxt_addr = '0;
    unique case (st_q)
      ST_RUN, ST_ARMED, ST_TRAIL: begin
        if (go) begin
          nxt_type = 3'(CYC_INTERNAL);
        end else if (fetch_vld) begin
          nxt_type = 3'(CYC_FETCH);
          nxt_addr = fetch_addr;
        end
      end
      ST_INT:     nxt_type = 3'(CYC_INTERNAL);
      ST_VEC: begin
        nxt_type = 3'(CYC_VECTOR);
        nxt_addr = VEC_A;
      end
      ST_PUSH_HI: begin
        nxt_type = 3'(CYC_STACK);
        nxt_addr = sp_q - SHORT_B;
      end
      ST_PUSH_LO: begin
        nxt_type = 3'(CYC_STACK);
        nxt_addr = sp_q - LONG_B;
      end
      ST_RESUME: begin
        nxt_type = 3'(CYC_FETCH);
        nxt_addr = ret_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      pc_q  <= '0;
      sp_q  <= '0;
      ret_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (hit) begin
            pc_q <= fetch_addr;
            st_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (insn_done) ret_q <= pc_q + ilen;
          if (insn_done && !insn_long) st_q <= ST_TRAIL;
        end
        ST_TRAIL: begin
          if (insn_done) ret_q <= ret_q + ilen;
        end
        ST_INT: begin
          if (cnt_q == '0) st_q  <= ST_VEC;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_VEC:     st_q <= ST_PUSH_HI;
        ST_PUSH_HI: st_q <= ST_PUSH_LO;
        ST_PUSH_LO: st_q <= ST_RESUME;
        ST_RESUME:  st_q <= ST_RUN;
        default:    st_q <= ST_RUN;
      endcase
      if (go) begin
        sp_q <= sp_in;
        if (INT_CYCLES > 1) begin
          st_q  <= ST_INT;
          cnt_q <= CW'(INT_CYCLES - 2);
        end else begin
          st_q  <= ST_VEC;
        end
      end
    end
  end

  assign ret_addr = ret_q;

endmodule

// File: rtl/fbu_rec.sv
module fbu_rec #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    nxt_type,
  input  logic [AW-1:0] nxt_addr,
  output logic [2:0]    cyc_type,
  output logic [AW-1:0] cyc_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_type <= '0;
      cyc_addr <= '0;
    end else begin
      cyc_type <= nxt_type;
      cyc_addr <= nxt_addr;
    end
  end

endmodule

// File: rtl/fetch_break_unit.sv
module fetch_break_unit #(
  parameter int          AW         = 16,
  parameter int          INT_CYCLES = 2,
  parameter logic [15:0] VEC_ADDR   = 16'h0036
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic          insn_done,
  input  logic          insn_long,
  input  logic [AW-1:0] sp_in,
  output logic          brk_req,
  output logic [2:0]    cyc_type,
  output logic [AW-1:0] cyc_addr,
  output logic [AW-1:0] ret_addr
);

  logic [AW-1:0] brk_addr_q;
  logic          brk_en_q;
  logic          seq_run;
  logic          hit;
  logic [2:0]    nxt_type;
  logic [AW-1:0] nxt_addr;

  fbu_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .brk_addr(brk_addr_q), .brk_en(brk_en_q)
  );

  fbu_match #(.AW(AW)) u_match (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .brk_addr(brk_addr_q), .brk_en(brk_en_q), .run(seq_run),
    .hit(hit), .brk_req(brk_req)
  );

  fbu_seq #(.AW(AW), .INT_CYCLES(INT_CYCLES), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .insn_done(insn_done), .insn_long(insn_long),
    .sp_in(sp_in), .run(seq_run), .nxt_type(nxt_type), .nxt_addr(nxt_addr),
    .ret_addr(ret_addr)
  );

  fbu_rec #(.AW(AW)) u_rec (
    .clk(clk), .rst_n(rst_n), .nxt_type(nxt_type), .nxt_addr(nxt_addr),
    .cyc_type(cyc_type), .cyc_addr(cyc_addr)
  );

endmodule

// File: rtl/fetch_break_unit_chk.sv
module fetch_break_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_vld,
  input logic [AW-1:0] fetch_addr,
  input logic          brk_req,
  input logic [2:0]    cyc_type,
  input logic [AW-1:0] cyc_addr,
  input logic [AW-1:0] ret_addr,
  input logic [AW-1:0] brk_addr,
  input logic          brk_en,
  input logic          run
);

  localparam logic [2:0] T_FETCH = 3'd1;
  localparam logic [2:0] T_INT   = 3'd2;
  localparam logic [2:0] T_VEC   = 3'd3;
  localparam logic [2:0] T_STACK = 3'd4;

  assert_req_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(fetch_vld && fetch_addr == brk_addr));

  assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(brk_en));

  assert_no_req_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(run));

  assert_vector_after_internal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == T_VEC) |-> ($past(cyc_type) == T_INT));

  assert_stack_after_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == T_VEC) |=> (cyc_type == T_STACK));

  assert_stack_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == T_STACK && $past(cyc_type) == T_VEC)
      |=> (cyc_type == T_STACK && cyc_addr == $past(cyc_addr) - AW'(2)));

  assert_resume_at_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == T_STACK && $past(cyc_type) == T_STACK)
      |=> (cyc_type == T_FETCH && cyc_addr == ret_addr));

endmodule

bind fetch_break_unit fetch_break_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
  .brk_req(brk_req), .cyc_type(cyc_type), .cyc_addr(cyc_addr),
  .ret_addr(ret_addr), .brk_addr(brk_addr_q), .brk_en(brk_en_q), .run(seq_run)
);

// File: tb/fetch_break_unit_bench.sv
module fetch_break_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  typedef struct {
    logic [2:0]    t;
    logic [AW-1:0] a;
    string         req;
  } rec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          fetch_vld = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          insn_done = 1'b0, insn_long = 1'b0;
  logic [AW-1:0] sp_in = '0;
  logic          brk_req;
  logic [2:0]    cyc_type;
  logic [AW-1:0] cyc_addr, ret_addr;

  rec_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   mon_on = 1'b0, done_flag = 1'b0;

  fetch_break_unit u_fetch_break_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .insn_done(insn_done), .insn_long(insn_long), .sp_in(sp_in),
    .brk_req(brk_req), .cyc_type(cyc_type), .cyc_addr(cyc_addr),
    .ret_addr(ret_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] t, input logic [AW-1:0] a, input string req);
    rec_t r;
    r.t = t; r.a = a; r.req = req;
    exp_q.push_back(r);
  endtask

  // scoreboard monitor: every non-idle record must match the queue head
  always @(negedge clk) begin
    if (mon_on && cyc_type != 3'd0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected record type", int'(cyc_type), 0);
      end else begin
        rec_t r;
        r = exp_q.pop_front();
        check(cyc_type == r.t, r.req, "record type", int'(cyc_type), int'(r.t));
        check(cyc_addr == r.a, r.req, "record addr", int'(cyc_addr), int'(r.a));
      end
    end
  end

  task automatic step(input bit fv, input logic [AW-1:0] fa, input bit dn,
                      input bit ln, input bit rec);
    fetch_vld = fv; fetch_addr = fa; insn_done = dn; insn_long = ln;
    if (rec) push(3'd1, fa, "R2");
    @(negedge clk);
    fetch_vld = 1'b0; insn_done = 1'b0; insn_long = 1'b0;
  endtask

  task automatic cfg_write(input bit sel, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_exc(input logic [AW-1:0] sp, input logic [AW-1:0] ret);
    push(3'd2, '0, "R7");
    push(3'd2, '0, "R7");
    push(3'd3, 16'h0036, "R7");
    push(3'd4, sp - 16'd2, "R7");
    push(3'd4, sp - 16'd4, "R7");
    push(3'd1, ret, "R9");
  endtask

  // five remaining exception clocks; matching fetches are driven and ignored
  task automatic ride_out(input logic [AW-1:0] noise);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, noise, 1'b0, 1'b0, 1'b0);
      check(brk_req == 1'b0, "R8", "request during exception", int'(brk_req), 0);
    end
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    // R1 reset state
    check(cyc_type == 3'd0, "R1", "reset type", int'(cyc_type), 0);
    check(brk_req == 1'b0, "R1", "reset brk_req", int'(brk_req), 0);
    check(ret_addr == '0, "R1", "reset ret_addr", int'(ret_addr), 0);
    step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b1);
    check(brk_req == 1'b0, "R1", "disabled after reset", int'(brk_req), 0);

    // R2 pass-through with gaps
    step(1'b1, 16'h1000, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    check(cyc_type == 3'd0, "R2", "idle record", int'(cyc_type), 0);
    step(1'b1, 16'h1002, 1'b0, 1'b0, 1'b1);

    // R4 address loaded, enable still 0
    cfg_write(1'b0, 16'h0312);
    step(1'b1, 16'h0312, 1'b0, 1'b0, 1'b1);
    check(brk_req == 1'b0, "R4", "no request while disabled", int'(brk_req), 0);
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    check(cyc_type == 3'd0, "R4", "no exception while disabled", int'(cyc_type), 0);

    // R3/R5: short break instruction, short neighbour executes too
    cfg_write(1'b1, 16'h0001);
    sp_in = 16'hFF00;
    step(1'b1, 16'h0310, 1'b0, 1'b0, 1'b1);
    step(1'b1, 16'h0312, 1'b1, 1'b0, 1'b1);
    check(brk_req == 1'b1, "R3", "request after hit", int'(brk_req), 1);
    step(1'b1, 16'h0314, 1'b1, 1'b0, 1'b1);
    check(brk_req == 1'b0, "R3", "request one clock only", int'(brk_req), 0);
    step(1'b1, 16'h0316, 1'b0, 1'b0, 1'b1);
    push_exc(16'hFF00, 16'h0316);
    step(1'b1, 16'h0318, 1'b1, 1'b0, 1'b0);
    check(ret_addr == 16'h0316, "R5", "return after short pair", int'(ret_addr), 'h316);
    ride_out(16'h0312);

    // R6: long break instruction, neighbour not executed
    sp_in = 16'hFE80;
    step(1'b1, 16'h0312, 1'b1, 1'b0, 1'b1);
    check(brk_req == 1'b1, "R6", "request on long case", int'(brk_req), 1);
    push_exc(16'hFE80, 16'h0316);
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    check(ret_addr == 16'h0316, "R6", "return after long insn", int'(ret_addr), 'h316);
    ride_out(16'h0312);

    // R8: re-hit while pending raises nothing
    step(1'b1, 16'h0312, 1'b0, 1'b0, 1'b1);
    step(1'b1, 16'h0312, 1'b0, 1'b0, 1'b1);
    check(brk_req == 1'b0, "R8", "re-hit while pending", int'(brk_req), 0);
    push_exc(16'hFE80, 16'h0316);
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    ride_out(16'h0000);

    // R5: new address, short break then long neighbour
    cfg_write(1'b0, 16'h0400);
    sp_in = 16'h8000;
    step(1'b1, 16'h0400, 1'b0, 1'b0, 1'b1);
    check(brk_req == 1'b1, "R3", "request at new address", int'(brk_req), 1);
    step(1'b1, 16'h0402, 1'b1, 1'b0, 1'b1);
    push_exc(16'h8000, 16'h0406);
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    check(ret_addr == 16'h0406, "R5", "return short+long", int'(ret_addr), 'h406);
    ride_out(16'h0400);

    // R4: disable again
    cfg_write(1'b1, 16'h0000);
    step(1'b1, 16'h0400, 1'b0, 1'b0, 1'b1);
    check(brk_req == 1'b0, "R4", "no request after disable", int'(brk_req), 0);
    step(1'b0, '0, 1'b1, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0);

    check(exp_q.size() == 0, "R7", "records left unseen", exp_q.size(), 0);
    finish_run();
  end

endmodule